// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block runs on the reference input clock and produces a signed frequency-deviation word. A fractional-N feedback divider adds the word to its nominal ratio to spread the spectrum of the synthesized clock. The deviation follows a centre-spread triangle. Each modulation cycle starts at zero deviation and climbs to the positive peak. It then falls through zero to the negative peak and climbs back to zero. The rising half of the triangle therefore straddles the period boundary, and each falling half lasts half a period.

The period of each modulation cycle is not fixed. At every period boundary a 16-bit LFSR draws one of eight lengths L·(224 + 12k), k = 0..7. The lengths therefore lie between 224·L and 308·L input clocks, and their long-run average is 266·L. L comes from a 3-bit period code and the peak from a 3-bit depth code. Both codes, and a rise of the enable input, are taken up only at a period boundary, so the triangle never breaks in the middle of a cycle. A one-cycle pulse marks the first clock of every period.

Top module: `sscg_profile_gen`

## Requirements
- R1: While reset is asserted `dev_o` is zero. In the first clock after reset is released `period_start_o` is high. The first period lasts exactly 224 clocks with zero deviation throughout, whatever the inputs are.
- R2: Every later period lasts L·(224 + 12k) clocks for some k in 0..7. L is the value of `period_sel` for codes 1..7, and L = 8 for code 0.
- R3: Period lengths vary from cycle to cycle. Over a long run with a fixed code, their mean is 266·L.
- R4: With enable active for a whole period of length N = 4Q, the sample i clocks after the start has the value ±⌊P·u/Q⌋. Here q = ⌊i/Q⌋ and c = i mod Q. The offset u is c for even q and Q − c for odd q. The sign is negative for q ≥ 2.
- R5: The peak P is round(d · 0.0025 · 65536) for depth code d: 164, 328, 492, 655, 819, 983 and 1147 for d = 1..7. `dev_o` reaches +P and −P exactly once per period, and d = 0 gives zero deviation.
- R6: `dev_o` is zero in every clock that follows a clock edge at which `mod_en` was sampled low. After `mod_en` rises, the deviation stays zero until the next period boundary.
- R7: A change of `period_sel` or `depth_sel` during a period has no effect until the next period starts.
- R8: `period_start_o` is high for exactly one clock per period, in the first clock of the period, and `dev_o` is zero in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulation enable |
| period_sel | input | 3 | Modulation-period code (L = code, 0 means 8) |
| depth_sel | input | 3 | Modulation-depth code (0 = off, 1..7 = ±0.25%..±1.75%) |
| dev_o | output | 16 | Signed deviation in units of 1/65536 of the nominal ratio |
| period_start_o | output | 1 | One-clock pulse at the first clock of each period |

## Verification
The bound assertions check the following on every clock:
- the deviation stays within the latched peak;
- the deviation is zero after enable is sampled low;
- the pulse lasts one clock and falls on a zero sample;
- the latched peak and quarter length change only as a new period starts;
- the quarter length stays within its legal range;
- the selection register never becomes zero.

Only the bench scenarios can show the rest. They measure each period length against the legal set for L and compare every sample with the triangle formula. They also confirm that code changes and enable rises made in mid-period wait for the boundary, and that the long-run mean period is near 266·L.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  typedef logic [1:0] qtr_t;

  // Period multiplier L: codes 1..7 map to themselves, code 0 maps to 8.
  function automatic logic [3:0] period_mult(input logic [2:0] code);
    return (code == 3'd0) ? 4'd8 : {1'b0, code};
  endfunction

  // Peak deviation for depth code d: d * 0.25% of 2^fw, rounded to nearest.
  function automatic int unsigned peak_of(input int unsigned d, input int unsigned fw);
    return (d * (32'd1 << fw) + 32'd200) / 32'd400;
  endfunction

endpackage

// File: rtl/sscg_lfsr.sv
module sscg_lfsr #(
  parameter int unsigned      W    = 16,
  parameter logic [W-1:0]     TAPS = 16'hB400,
  parameter logic [W-1:0]     SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= SEED;
    else if (adv) state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/sscg_seq.sv
module sscg_seq #(
  parameter int unsigned QW     = 10,
  parameter int unsigned PW     = 11,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned BASE_Q = 56,
  parameter int unsigned STEP_Q = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       period_code,
  input  logic [2:0]       depth_code,
  input  logic [2:0]       sel,
  output logic [QW-1:0]    qcnt_o,
  output logic [QW-1:0]    qlen_o,
  output sscg_pkg::qtr_t   qtr_o,
  output logic [PW-1:0]    peak_o,
  output logic             act_o,
  output logic             start_o,
  output logic             boundary_o
);

  logic [QW-1:0]  qcnt_q, qcnt_d;
  logic [QW-1:0]  qlen_q, qlen_d;
  sscg_pkg::qtr_t qtr_q, qtr_d;
  logic [PW-1:0]  peak_q, peak_d;
  logic           act_q, act_d;
  logic           quarter_end, boundary;
  logic [QW-1:0]  lmul, base_q;
  logic [PW-1:0]  peak_tab [8];

  // Peak table, computed from the depth-code rule at elaboration.
  for (genvar gi = 0; gi < 8; gi++) begin : g_peak
    assign peak_tab[gi] = PW'(sscg_pkg::peak_of(gi, FRAC_W));
  end

  assign quarter_end = (qcnt_q == qlen_q - QW'(1));
  assign boundary    = quarter_end && (qtr_q == 2'd3);

  always_comb begin
    lmul   = QW'(sscg_pkg::period_mult(period_code));
    base_q = QW'(BASE_Q) + QW'(STEP_Q) * QW'(sel);
    qlen_d = lmul * base_q;
    peak_d = peak_tab[depth_code];
  end

  always_comb begin
    qcnt_d = qcnt_q + QW'(1);
    qtr_d  = qtr_q;
    act_d  = act_q & en;
    if (quarter_end) begin
      qcnt_d = '0;
      qtr_d  = qtr_q + 2'd1;
    end
    if (boundary) act_d = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      qtr_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      qcnt_q <= qcnt_d;
      qtr_q  <= qtr_d;
      act_q  <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qlen_q <= QW'(BASE_Q);
      peak_q <= '0;
    end else if (boundary) begin
      qlen_q <= qlen_d;
      peak_q <= peak_d;
    end
  end

  assign qcnt_o     = qcnt_q;
  assign qlen_o     = qlen_q;
  assign qtr_o      = qtr_q;
  assign peak_o     = peak_q;
  assign act_o      = act_q;
  assign start_o    = (qtr_q == 2'd0) && (qcnt_q == '0);
  assign boundary_o = boundary;

endmodule

// File: rtl/sscg_shaper.sv
module sscg_shaper #(
  parameter int unsigned QW    = 10,
  parameter int unsigned PW    = 11,
  parameter int unsigned DEV_W = 16
) (
  input  logic [QW-1:0]           qcnt,
  input  logic [QW-1:0]           qlen,
  input  sscg_pkg::qtr_t          qtr,
  input  logic [PW-1:0]           peak,
  input  logic                    act,
  output logic signed [DEV_W-1:0] dev_o
);

  localparam int unsigned MW = PW + QW;

  logic [QW-1:0]           u;
  logic [MW-1:0]           prod, mag;
  logic signed [DEV_W-1:0] mag_s;

  always_comb begin
    u     = qtr[0] ? (qlen - qcnt) : qcnt;
    prod  = MW'(peak) * MW'(u);
    mag   = prod / MW'(qlen);
    mag_s = DEV_W'(mag);
    if (!act)        dev_o = '0;
    else if (qtr[1]) dev_o = -mag_s;
    else             dev_o = mag_s;
  end

endmodule

// File: rtl/sscg_profile_gen.sv
module sscg_profile_gen #(
  parameter int unsigned          FRAC_W     = 16,
  parameter int unsigned          DEV_W      = 16,
  parameter int unsigned          LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]    LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0]    LFSR_SEED  = 16'hACE1,
  parameter int unsigned          BASE_LEN   = 224,
  parameter int unsigned          STEP_LEN   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic [2:0]              period_sel,
  input  logic [2:0]              depth_sel,
  output logic signed [DEV_W-1:0] dev_o,
  output logic                    period_start_o
);

  localparam int unsigned BASE_Q   = BASE_LEN / 4;
  localparam int unsigned STEP_Q   = STEP_LEN / 4;
  localparam int unsigned QMAX     = 8 * (BASE_Q + 7 * STEP_Q);
  localparam int unsigned QW       = $clog2(QMAX + 1);
  localparam int unsigned PEAK_MAX = sscg_pkg::peak_of(7, FRAC_W);
  localparam int unsigned PW       = $clog2(PEAK_MAX + 1);

  logic [LFSR_W-1:0] lfsr_w;
  logic [QW-1:0]     qcnt_w, qlen_w;
  sscg_pkg::qtr_t    qtr_w;
  logic [PW-1:0]     peak_w;
  logic              act_w, boundary_w;

  sscg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (boundary_w),
    .state_o (lfsr_w)
  );

  sscg_seq #(.QW(QW), .PW(PW), .FRAC_W(FRAC_W), .BASE_Q(BASE_Q), .STEP_Q(STEP_Q)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (mod_en),
    .period_code (period_sel),
    .depth_code  (depth_sel),
    .sel         (lfsr_w[2:0]),
    .qcnt_o      (qcnt_w),
    .qlen_o      (qlen_w),
    .qtr_o       (qtr_w),
    .peak_o      (peak_w),
    .act_o       (act_w),
    .start_o     (period_start_o),
    .boundary_o  (boundary_w)
  );

  sscg_shaper #(.QW(QW), .PW(PW), .DEV_W(DEV_W)) u_shape (
    .qcnt  (qcnt_w),
    .qlen  (qlen_w),
    .qtr   (qtr_w),
    .peak  (peak_w),
    .act   (act_w),
    .dev_o (dev_o)
  );

endmodule

// File: rtl/sscg_profile_chk.sv
module sscg_profile_chk #(
  parameter int unsigned DEV_W  = 16,
  parameter int unsigned QW     = 10,
  parameter int unsigned PW     = 11,
  parameter int unsigned LFSR_W = 16,
  parameter int unsigned QMIN   = 56,
  parameter int unsigned QMAX   = 616
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic signed [DEV_W-1:0] dev_o,
  input  logic                    period_start_o,
  input  logic [PW-1:0]           peak_q,
  input  logic [QW-1:0]           qlen_q,
  input  logic [LFSR_W-1:0]       lfsr_q
);

  a_r5_within_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dev_o) <= int'(peak_q)) && (int'(dev_o) >= -int'(peak_q)));

  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (dev_o == '0));

  a_r8_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |-> (dev_o == '0));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |=> !period_start_o);

  a_r7_peak_held: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start_o |-> $stable(peak_q));

  a_r7_qlen_held: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start_o |-> $stable(qlen_q));

  a_r2_qlen_range: assert property (@(posedge clk) disable iff (!rst_n)
    (qlen_q >= QW'(QMIN)) && (qlen_q <= QW'(QMAX)));

  a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

bind sscg_profile_gen sscg_profile_chk #(
  .DEV_W(DEV_W), .QW(QW), .PW(PW), .LFSR_W(LFSR_W), .QMIN(BASE_Q), .QMAX(QMAX)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mod_en         (mod_en),
  .dev_o          (dev_o),
  .period_start_o (period_start_o),
  .peak_q         (peak_w),
  .qlen_q         (qlen_w),
  .lfsr_q         (lfsr_w)
);

// File: tb/sim_sscg_profile_gen.sv
module sim_sscg_profile_gen;

  logic              clk;
  logic              rst_n;
  logic              mod_en;
  logic [2:0]        period_sel;
  logic [2:0]        depth_sel;
  logic signed [15:0] dev_o;
  logic              period_start_o;

  sscg_profile_gen u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .mod_en         (mod_en),
    .period_sel     (period_sel),
    .depth_sel      (depth_sel),
    .dev_o          (dev_o),
    .period_start_o (period_start_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  int  starts_seen = 0;

  // scoreboard state
  int  dev_q[$];
  bit  act_q[$];
  bit  first_period = 1;
  bit  cur_act = 0;
  int  cfg_l = 1;
  int  cfg_p = 0;
  logic [2:0] snap_p, snap_d;
  bit  cfg_changed = 0;

  // statistics for the L = 1 run
  int  st_sum = 0, st_cnt = 0, st_min = 1 << 30, st_max = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lmul(input logic [2:0] c);
    return (c == 3'd0) ? 8 : int'(c);
  endfunction

  function automatic int peak(input logic [2:0] d);
    return $rtoi(real'(d) * 0.0025 * 65536.0 + 0.5);
  endfunction

  task automatic close_period();
    int n, q, mism, fa, fe, mx, mn;
    bit all_act, ok;
    string tag;
    n = dev_q.size();
    if (first_period) begin
      chk(n == 224, "R1", "first period length", n, 224);
    end else begin
      ok = 0;
      for (int k = 0; k < 8; k++) if (n == cfg_l * (224 + 12 * k)) ok = 1;
      chk(ok, "R2", "period length in legal set", n, cfg_l * 266);
      if (cfg_l == 1) begin
        st_sum += n; st_cnt++;
        if (n < st_min) st_min = n;
        if (n > st_max) st_max = n;
      end
    end
    q = n / 4;
    mism = 0; fa = 0; fe = 0; all_act = 1; mx = -100000; mn = 100000;
    for (int i = 0; i < n; i++) begin
      int qt, c, u, mg, e;
      qt = i / q; c = i % q;
      u  = (qt % 2 == 1) ? (q - c) : c;
      mg = (cfg_p * u) / q;
      e  = (qt >= 2) ? -mg : mg;
      if (!act_q[i]) begin e = 0; all_act = 0; end
      if (dev_q[i] != e) begin
        if (mism == 0) begin fa = dev_q[i]; fe = e; end
        mism++;
      end
      if (dev_q[i] > mx) mx = dev_q[i];
      if (dev_q[i] < mn) mn = dev_q[i];
    end
    if (first_period)     tag = "R1";
    else if (!all_act)    tag = "R6";
    else if (cfg_changed) tag = "R7";
    else                  tag = "R4";
    chk((n % 4 == 0) && (mism == 0), tag, "profile sample", fa, fe);
    chk(dev_q[0] == 0, "R8", "deviation at period start", dev_q[0], 0);
    if (all_act && !first_period)
      chk((mx == cfg_p) && (mn == -cfg_p), "R5", "peak magnitude", mx, cfg_p);
    dev_q.delete();
    act_q.delete();
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (period_start_o) begin
        if (dev_q.size() > 0) begin
          close_period();
          first_period = 0;
        end
        starts_seen++;
        cfg_changed = 0;
        snap_p = period_sel;
        snap_d = depth_sel;
        if (first_period) begin
          cfg_l = 1; cfg_p = 0; cur_act = 0;
        end else begin
          cfg_l = lmul(period_sel); cfg_p = peak(depth_sel); cur_act = mod_en;
        end
      end else begin
        cur_act = cur_act && mod_en;
        if (period_sel != snap_p || depth_sel != snap_d) cfg_changed = 1;
      end
      dev_q.push_back(int'(dev_o));
      act_q.push_back(cur_act);
    end
  end

  task automatic wait_starts(input int n);
    int target;
    target = starts_seen + n;
    while (starts_seen < target) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mod_en = 1'b1; period_sel = 3'd1; depth_sel = 3'd7;
    repeat (5) @(posedge clk);
    #1;
    chk(dev_o == 0, "R1", "deviation in reset", int'(dev_o), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(period_start_o == 1'b1, "R1", "start pulse after reset", int'(period_start_o), 1);
    #1;
    // long run at L = 1, full depth
    wait_starts(201);
    // code change in mid-period: applies from next boundary
    wait_cycles(50);
    period_sel = 3'd2; depth_sel = 3'd3;
    wait_starts(3);
    // depth code 0: no modulation
    wait_cycles(10);
    depth_sel = 3'd0;
    wait_starts(3);
    // enable fall and rise in mid-period
    depth_sel = 3'd4;
    wait_starts(2);
    wait_cycles(100);
    mod_en = 1'b0;
    wait_starts(2);
    wait_cycles(30);
    mod_en = 1'b1;
    wait_starts(3);
    // period code 0 means L = 8
    period_sel = 3'd0; depth_sel = 3'd5;
    wait_starts(3);
    period_sel = 3'd7; depth_sel = 3'd1;
    wait_starts(3);
    // long-run statistics of the L = 1 run
    chk((st_cnt > 0) && (st_sum >= (266 - 12) * st_cnt) && (st_sum <= (266 + 12) * st_cnt),
        "R3", "mean period length", (st_cnt > 0) ? st_sum / st_cnt : 0, 266);
    chk(st_max > st_min, "R3", "period length spread", st_max - st_min, 12);
    done = 1;
    summary();
    $finish;
  end

endmodule